// File: doc/BRIEF.md
# Downward-Growing Stack Pointer with Return Guard

This block keeps the 16-bit stack pointer of a small 8-bit processor. It forms the memory address for the four stack operations: push of a data byte, pop of a data byte, subroutine call (saving a 16-bit return address) and subroutine return. The stack starts at the top of memory and grows toward lower addresses, one 16-bit memory word per entry. Every stack address is 24 bits wide and its upper byte is always all ones, so the stack lives in the top 64 Ki-word page of memory.

Writing operations (push, call) use the current pointer as the address and then step the pointer down. Reading operations (pop, return) step the pointer up first and read at the new value. A return takes two cycles in the processor: the first reads the saved address and the second fetches the instruction there. During the second cycle the program counter raises its halted signal. While that signal is high the pointer is frozen, so a return raises it by exactly one. The pointer wraps modulo 2^16 and has no overflow detection. The memory itself and the stored values are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, `sp_value` is 0xFFFF, and with `stk_op`=0 the address is 0xFFFFFF with `mem_we`=0 and `mem_re`=0.
- R2: A push (`stk_op`=1) with `pc_halted`=0 drives `mem_we`=1, `mem_be`=2'b01 and the address {0xFF, `sp_value`} in that cycle; on the next edge `sp_value` falls by 1.
- R3: A call (`stk_op`=3) with `pc_halted`=0 drives `mem_we`=1, `mem_be`=2'b11 and the address {0xFF, `sp_value`}; on the next edge `sp_value` falls by 1.
- R4: A pop (`stk_op`=2) with `pc_halted`=0 drives `mem_re`=1, `mem_be`=2'b01 and the address {0xFF, `sp_value`+1}; on the next edge `sp_value` rises by 1.
- R5: A return (`stk_op`=4) reads with `mem_be`=2'b11 at {0xFF, `sp_value`+1} and raises the pointer by 1 in its first cycle; in its second cycle, with `pc_halted`=1, it reads at {0xFF, `sp_value`}, the same word, and the pointer does not change, so the pointer rises by exactly 1 over the whole return.
- R6: While `pc_halted`=1 the pointer holds for every operation, and a push or call asserts no `mem_we`.
- R7: The upper 8 bits of `mem_addr` are 0xFF in every cycle.
- R8: The pointer wraps: a pop at 0xFFFF reads 0xFF0000 and leaves 0x0000; a push at 0x0000 writes 0xFF0000 and leaves 0xFFFF.
- R9: With `stk_op`=0 or any unused code (5 to 7) the pointer holds, `mem_we`=0, `mem_re`=0, `mem_be`=0 and the address is {0xFF, `sp_value`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stk_op | input | 3 | 0 none, 1 push, 2 pop, 3 call, 4 return, 5-7 none |
| pc_halted | input | 1 | Program counter halted (second cycle of a return) |
| mem_addr | output | 24 | Stack memory address, upper byte 0xFF |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_be | output | 2 | Byte lanes: 01 low byte, 11 full word |
| sp_value | output | 16 | Current stack pointer |

## Verification
The assertions watch every cycle for the pointer steps: a push or call lowers it by one and the written address is one above the new pointer, a pop or return raises it to the address just read, and the halted signal or an idle code leaves it unchanged. Only the bench scenarios show the absolute values: the reset value, the exact addresses of a push/pop series returning to the top, the two-cycle return reading the same word twice, and the wrap through zero in both directions.

// File: rtl/stk_pkg.sv
// Shared definitions for the stack pointer unit.
// Assumes the operation code is presented for one cycle per stack access.
package stk_pkg;
    typedef enum logic [2:0] {
        STK_NONE = 3'd0,
        STK_PUSH = 3'd1,
        STK_POP  = 3'd2,
        STK_CALL = 3'd3,
        STK_RET  = 3'd4
    } stk_op_e;
endpackage

// File: rtl/stk_next.sv
// Next-state and access logic for the stack pointer.
// Writes use the current pointer then step down; reads step up then use
// the new pointer. The halted flag freezes the pointer and blocks writes.
module stk_next #(
    parameter int PTR_W = 16,
    parameter int LANES = 2
) (
    input  logic [PTR_W-1:0]  sp,
    input  stk_pkg::stk_op_e  op,
    input  logic              halted,
    output logic [PTR_W-1:0]  sp_nxt,
    output logic [PTR_W-1:0]  acc_ptr,
    output logic              we,
    output logic              re,
    output logic [LANES-1:0]  be
);
    import stk_pkg::*;

    localparam logic [PTR_W-1:0] PTR_ONE  = {{(PTR_W-1){1'b0}}, 1'b1};
    localparam logic [LANES-1:0] BE_LOW   = {{(LANES-1){1'b0}}, 1'b1};
    localparam logic [LANES-1:0] BE_WORD  = {LANES{1'b1}};

    logic grow_down;
    logic grow_up;
    logic wide;

    // Classify the operation.
    always_comb begin
        grow_down = (op == STK_PUSH) || (op == STK_CALL);
        grow_up   = (op == STK_POP)  || (op == STK_RET);
        wide      = (op == STK_CALL) || (op == STK_RET);
    end

    // Select the access pointer, strobes and next pointer value.
    always_comb begin
        sp_nxt  = sp;
        acc_ptr = sp;
        we      = 1'b0;
        re      = 1'b0;
        be      = '0;
        if (grow_down) begin
            be = wide ? BE_WORD : BE_LOW;
            if (!halted) begin
                we     = 1'b1;
                sp_nxt = sp - PTR_ONE;
            end
        end else if (grow_up) begin
            be = wide ? BE_WORD : BE_LOW;
            re = 1'b1;
            if (!halted) begin
                acc_ptr = sp + PTR_ONE;
                sp_nxt  = sp + PTR_ONE;
            end
        end
    end
endmodule

// File: rtl/stk_addr.sv
// Forms the wide memory address from the stack access pointer.
// Assumes the stack page occupies the top of memory: the upper bits are
// tied to a fixed fill value.
module stk_addr #(
    parameter int               PTR_W  = 16,
    parameter int               ADDR_W = 24,
    parameter logic [ADDR_W-PTR_W-1:0] HI_FILL = '1
) (
    input  logic [PTR_W-1:0]  acc_ptr,
    output logic [ADDR_W-1:0] addr
);
    // Concatenate fixed page bits with the pointer.
    always_comb addr = {HI_FILL, acc_ptr};
endmodule

// File: rtl/stack_ptr_unit.sv
// Stack pointer unit: holds the pointer, drives stack memory address and
// strobes for push, pop, call and return. Assumes the program counter
// raises pc_halted during the second cycle of a two-cycle return.
module stack_ptr_unit #(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 24,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        stk_op,
    input  logic              pc_halted,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [LANES-1:0]  mem_be,
    output logic [PTR_W-1:0]  sp_value
);
    import stk_pkg::*;

    localparam int HI_W = ADDR_W - PTR_W;
    localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    stk_op_e          op_e;
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_d;
    logic [PTR_W-1:0] acc_ptr;

    // Decode the raw code; unused codes act as no operation.
    always_comb op_e = (stk_op > 3'd4) ? STK_NONE : stk_op_e'(stk_op);

    stk_next #(.PTR_W(PTR_W), .LANES(LANES)) u_next (
        .sp      (sp_q),
        .op      (op_e),
        .halted  (pc_halted),
        .sp_nxt  (sp_d),
        .acc_ptr (acc_ptr),
        .we      (mem_we),
        .re      (mem_re),
        .be      (mem_be)
    );

    stk_addr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .HI_FILL({HI_W{1'b1}})) u_addr (
        .acc_ptr (acc_ptr),
        .addr    (mem_addr)
    );

    // Pointer register, reset to the top of the stack page.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '1;
        else        sp_q <= sp_d;
    end

    assign sp_value = sp_q;

    // Write operations lower the pointer by one (R2, R3).
    p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == STK_PUSH || op_e == STK_CALL) && !pc_halted)
        |=> (sp_q == $past(sp_q) - PTR_ONE));

    // The written slot sits one above the new pointer (R3).
    p_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ($past(mem_addr[PTR_W-1:0]) == sp_q + PTR_ONE));

    // Reads leave the pointer at the address just read (R4).
    p_read_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == STK_POP || op_e == STK_RET) && !pc_halted)
        |=> (sp_q == $past(mem_addr[PTR_W-1:0])));

    // Halted second return cycle reads the same word as the first (R5).
    p_ret_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == STK_RET && !pc_halted) ##1 (op_e == STK_RET && pc_halted)
        |-> (mem_addr == $past(mem_addr)));

    // Halt freezes the pointer (R6).
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_halted |=> $stable(sp_q));

    // No write while halted (R6).
    p_halt_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_halted |-> !mem_we);

    // Idle codes keep the pointer and strobes quiet (R9).
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == STK_NONE) |=> $stable(sp_q));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == STK_NONE) |-> (!mem_we && !mem_re));
endmodule

// File: tb/tb_stack_ptr_unit.sv
// Directed bench for the stack pointer unit.
module tb_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  stk_op = 3'd0;
    logic        pc_halted = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic [1:0]  mem_be;
    logic [15:0] sp_value;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_sp;

    stack_ptr_unit dut (
        .clk(clk), .rst_n(rst_n), .stk_op(stk_op), .pc_halted(pc_halted),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_be(mem_be), .sp_value(sp_value)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Apply one operation: drive at negedge, check outputs, clock, check pointer.
    task automatic do_op(input string req, input logic [2:0] op, input logic halt,
                         input logic [15:0] exp_acc, input logic exp_we,
                         input logic exp_re, input logic [1:0] exp_be,
                         input logic [15:0] exp_next);
        @(negedge clk);
        stk_op    = op;
        pc_halted = halt;
        #1;
        chk(req, "addr", {8'h0, mem_addr}, {8'h0, 8'hFF, exp_acc});
        chk("R7", "addr upper byte", {24'h0, mem_addr[23:16]}, 32'hFF);
        chk(req, "we", {31'h0, mem_we}, {31'h0, exp_we});
        chk(req, "re", {31'h0, mem_re}, {31'h0, exp_re});
        chk(req, "be", {30'h0, mem_be}, {30'h0, exp_be});
        @(negedge clk);
        stk_op    = 3'd0;
        pc_halted = 1'b0;
        chk(req, "sp after", {16'h0, sp_value}, {16'h0, exp_next});
        exp_sp = exp_next;
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "sp reset", {16'h0, sp_value}, 32'hFFFF);
        chk("R1", "addr reset", {8'h0, mem_addr}, 32'hFFFFFF);
        chk("R1", "strobes reset", {30'h0, mem_we, mem_re}, 32'h0);
        exp_sp = 16'hFFFF;
    endtask

    task automatic t_idle_r9();
        do_op("R9", 3'd0, 1'b0, exp_sp, 1'b0, 1'b0, 2'b00, exp_sp);
        do_op("R9", 3'd5, 1'b0, exp_sp, 1'b0, 1'b0, 2'b00, exp_sp);
        do_op("R9", 3'd7, 1'b0, exp_sp, 1'b0, 1'b0, 2'b00, exp_sp);
    endtask

    task automatic t_push_pop_r2_r4();
        for (int i = 0; i < 3; i++)
            do_op("R2", 3'd1, 1'b0, exp_sp, 1'b1, 1'b0, 2'b01, exp_sp - 16'd1);
        chk("R2", "sp after 3 pushes", {16'h0, sp_value}, 32'hFFFC);
        for (int i = 0; i < 3; i++)
            do_op("R4", 3'd2, 1'b0, exp_sp + 16'd1, 1'b0, 1'b1, 2'b01, exp_sp + 16'd1);
        chk("R4", "sp back at top", {16'h0, sp_value}, 32'hFFFF);
    endtask

    task automatic t_call_ret_r3_r5();
        do_op("R2", 3'd1, 1'b0, exp_sp, 1'b1, 1'b0, 2'b01, exp_sp - 16'd1);
        do_op("R3", 3'd3, 1'b0, exp_sp, 1'b1, 1'b0, 2'b11, exp_sp - 16'd1);
        chk("R3", "sp after call", {16'h0, sp_value}, 32'hFFFD);
        // Two-cycle return: both cycles read word FFFE.
        @(negedge clk);
        stk_op = 3'd4; pc_halted = 1'b0;
        #1;
        chk("R5", "ret first addr", {8'h0, mem_addr}, 32'hFFFFFE);
        chk("R5", "ret be", {30'h0, mem_be}, 32'h3);
        chk("R5", "ret re", {31'h0, mem_re}, 32'h1);
        @(negedge clk);
        pc_halted = 1'b1;
        #1;
        chk("R5", "ret second addr", {8'h0, mem_addr}, 32'hFFFFFE);
        chk("R5", "sp mid ret", {16'h0, sp_value}, 32'hFFFE);
        @(negedge clk);
        stk_op = 3'd0; pc_halted = 1'b0;
        chk("R5", "sp after ret", {16'h0, sp_value}, 32'hFFFE);
        exp_sp = 16'hFFFE;
        do_op("R4", 3'd2, 1'b0, 16'hFFFF, 1'b0, 1'b1, 2'b01, 16'hFFFF);
    endtask

    task automatic t_halt_r6();
        do_op("R6", 3'd1, 1'b1, exp_sp, 1'b0, 1'b0, 2'b01, exp_sp);
        do_op("R6", 3'd3, 1'b1, exp_sp, 1'b0, 1'b0, 2'b11, exp_sp);
        do_op("R6", 3'd2, 1'b1, exp_sp, 1'b0, 1'b1, 2'b01, exp_sp);
    endtask

    task automatic t_wrap_r8();
        do_op("R8", 3'd2, 1'b0, 16'h0000, 1'b0, 1'b1, 2'b01, 16'h0000);
        do_op("R8", 3'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 2'b01, 16'hFFFF);
    endtask

    initial begin
        t_reset_r1();
        t_idle_r9();
        t_push_pop_r2_r4();
        t_call_ret_r3_r5();
        t_halt_r6();
        t_wrap_r8();
        // Reset from a non-top pointer.
        do_op("R2", 3'd1, 1'b0, exp_sp, 1'b1, 1'b0, 2'b01, exp_sp - 16'd1);
        t_reset_r1();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule